// File: doc/BRIEF.md
# Fall-Through Audio Channel FIFO Port

This block buffers 16-bit audio samples between a processor and the serial side of a digital audio interface. There are two channels, left and right. Each channel has a receive FIFO, filled by the serial logic and drained by the processor, and a transmit FIFO, filled by the processor and drained by the serial logic. Both FIFOs are eight-slot fall-through shift chains. A new sample enters the top slot and drops one slot per clock until it rests on the slot above the last valid one. When the bottom entry is taken, every valid entry above it moves down one slot in the same clock.

The processor reaches the block over a plain 32-bit register bus. Each channel has a data register. Reading it takes the oldest receive sample and writing it queues a transmit sample. A shared control register switches a channel's FIFOs on or off. Each write to it carries a 5-bit channel-select code and an enable bit, and a write whose code matches neither channel changes nothing. A per-channel ready output follows the enable one clock later, so software can poll it before using the FIFOs. A disabled channel holds its FIFOs empty, and so does a low interface enable.

Top module: `audio_fifo_port`

## Requirements
- R1: The bus address map is: 0 is control, 1 is the left data register, 2 is the right data register, 3 is unused. Data registers carry the sample in bits 15:0. Bits 31:16 of a data write are ignored. Bus reads always return zero in bits 31:16. Reads of address 0 or 3 return zero.
- R2: A data-register read returns the oldest sample in that channel's receive FIFO. The read removes it, and the next-oldest sample is available to the following read.
- R3: A sample pushed into an empty FIFO on clock edge k occupies the bottom slot after edge k+7. The receive empty flag is high before that edge and low after it.
- R4: Data-register writes queue samples in the transmit FIFO. The serial output presents the oldest sample, and a serial pop removes it, in write order.
- R5: A control write with bits 20:16 equal to 0x0D loads bit 15 into the left enable. A control write with bits 20:16 equal to 0x11 loads bit 15 into the right enable. Any other code leaves both enables unchanged. The other control bits have no effect.
- R6: While a channel's enable is low, or the interface enable input is low, both of that channel's FIFOs and its overflow flag are cleared from the next clock on. Serial pushes, data writes and data reads to that channel have no effect, and data reads of it return zero.
- R7: Reading an empty receive FIFO returns zero and does not change the FIFO.
- R8: A data write to a full transmit FIFO, with no serial pop in the same clock, is dropped and sets the channel's overflow flag. The flag stays set until the channel is disabled.
- R9: Each channel's ready output equals that channel's enable as it stood one clock earlier.
- R10: A serial push into a full receive FIFO is dropped. The eight stored samples are kept and stay in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iface_en | input | 1 | Interface enable; low clears all FIFOs |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, registered |
| ser_rx_push | input | 2 | Per-channel receive push strobe (bit 0 left) |
| ser_rx_data | input | 32 | Receive samples, left in 15:0, right in 31:16 |
| ser_rx_full | output | 2 | Receive FIFO holds eight samples |
| ser_tx_pop | input | 2 | Per-channel transmit pop strobe |
| ser_tx_data | output | 32 | Bottom transmit samples, left in 15:0, right in 31:16 |
| ser_tx_empty | output | 2 | Transmit bottom slot is empty |
| cpu_rx_empty | output | 2 | Receive bottom slot is empty |
| cpu_tx_full | output | 2 | Transmit FIFO holds eight samples |
| tx_ovf | output | 2 | Sticky transmit overflow per channel |
| chan_ready | output | 2 | Enable state, one clock late |

## Verification
The bench times a single sample's fall through all eight slots. A chain that moved entries too fast or too slowly would clear the empty flag on the wrong edge. It fills both FIFO kinds past capacity and then drains them. A FIFO that overwrote the top slot, or let a dropped sample in, would return a wrong or extra value, and a missing sticky flag would show as a clear overflow bit. It writes control words with foreign channel codes and reserved bits set, to catch a decoder that reacts to the wrong field. It also disables channels that hold data, to catch a FIFO that keeps stale samples or accepts traffic while disabled.

// File: rtl/afp_pkg.sv
package afp_pkg;

  localparam int SEL_LO  = 16;
  localparam int SEL_HI  = 20;
  localparam int SEL_W   = SEL_HI - SEL_LO + 1;
  localparam int ENA_BIT = 15;

  localparam logic [SEL_W-1:0] CODE_LEFT  = 5'h0D;
  localparam logic [SEL_W-1:0] CODE_RIGHT = 5'h11;

  localparam logic [1:0] ADDR_CTRL = 2'd0;

  // one-hot channel hit for a channel-select code; zero for foreign codes
  function automatic logic [1:0] sel_decode(input logic [SEL_W-1:0] code);
    logic [1:0] hit;
    hit = 2'b00;
    if (code == CODE_LEFT)  hit = 2'b01;
    if (code == CODE_RIGHT) hit = 2'b10;
    return hit;
  endfunction

  // bus address of a channel data register
  function automatic logic [1:0] chan_addr(input int ch);
    return 2'(ch + 1);
  endfunction

endpackage

// File: rtl/afp_fifo.sv
module afp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] bot_data,
  output logic         bot_valid,
  output logic         full
);
  localparam int TOP = DEPTH - 1;

  logic [DEPTH-1:0]        vld;
  logic [DEPTH-1:0][W-1:0] dat;
  logic [DEPTH-1:0]        hole;
  logic                    pop_ok;

  assign pop_ok = pop && vld[0];

  // a slot is vacated this clock if it is empty, is being popped,
  // or anything below it is vacated (everything above shifts down)
  always_comb begin
    hole[0] = !vld[0] || pop_ok;
    for (int i = 1; i < DEPTH; i++) hole[i] = !vld[i] || hole[i-1];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic         v_q;
    logic [W-1:0] d_q;
    logic         nxt_v;
    logic [W-1:0] nxt_d;

    if (i == TOP) begin : g_top
      assign nxt_v = push;
      assign nxt_d = push_data;
    end else begin : g_mid
      assign nxt_v = vld[i+1];
      assign nxt_d = dat[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst || clear) v_q <= 1'b0;
      else if (hole[i]) v_q <= nxt_v;
    end

    always_ff @(posedge clk) begin
      if (hole[i] && nxt_v) d_q <= nxt_d;
    end

    assign vld[i] = v_q;
    assign dat[i] = d_q;
  end

  assign bot_valid = vld[0];
  assign bot_data  = vld[0] ? dat[0] : '0;
  assign full      = &vld;

endmodule

// File: rtl/afp_ctrl.sv
module afp_ctrl
  import afp_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SEL_W-1:0] sel,
  input  logic             ena,
  output logic [NCH-1:0]   en_q,
  output logic [NCH-1:0]   ready_q
);
  logic [NCH-1:0] hit;

  assign hit = wr ? NCH'(sel_decode(sel)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      ready_q <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) if (hit[c]) en_q[c] <= ena;
      ready_q <= en_q;
    end
  end

endmodule

// File: rtl/audio_fifo_port.sv
module audio_fifo_port
  import afp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int BUS_W    = 32,
  parameter int DEPTH    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 iface_en,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [1:0]           bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [1:0]           ser_rx_push,
  input  logic [2*SAMPLE_W-1:0] ser_rx_data,
  output logic [1:0]           ser_rx_full,
  input  logic [1:0]           ser_tx_pop,
  output logic [2*SAMPLE_W-1:0] ser_tx_data,
  output logic [1:0]           ser_tx_empty,
  output logic [1:0]           cpu_rx_empty,
  output logic [1:0]           cpu_tx_full,
  output logic [1:0]           tx_ovf,
  output logic [1:0]           chan_ready
);
  localparam int NCH = 2;

  logic [NCH-1:0]               en_q;
  logic [NCH-1:0]               active;
  logic [NCH-1:0]               cpu_pop;
  logic [NCH-1:0]               cpu_push;
  logic [NCH-1:0]               tx_drop;
  logic [NCH-1:0][SAMPLE_W-1:0] rx_bot;
  logic                         unused_rsvd;

  assign unused_rsvd = ^bus_wdata[BUS_W-1:SEL_HI+1];

  afp_ctrl #(.NCH(NCH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr && bus_addr == ADDR_CTRL),
    .sel     (bus_wdata[SEL_HI:SEL_LO]),
    .ena     (bus_wdata[ENA_BIT]),
    .en_q    (en_q),
    .ready_q (chan_ready)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic                hit;
    logic                rx_v;
    logic                tx_v;
    logic                tx_full;
    logic                ovf_q;
    logic [SAMPLE_W-1:0] tx_bot;

    assign active[c]   = en_q[c] && iface_en;
    assign hit         = (bus_addr == chan_addr(c));
    assign cpu_pop[c]  = bus_rd && hit && active[c];
    assign cpu_push[c] = bus_wr && hit && active[c];

    afp_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_rx (
      .clk       (clk),
      .rst       (rst),
      .clear     (!active[c]),
      .push      (ser_rx_push[c] && active[c]),
      .push_data (ser_rx_data[c*SAMPLE_W +: SAMPLE_W]),
      .pop       (cpu_pop[c]),
      .bot_data  (rx_bot[c]),
      .bot_valid (rx_v),
      .full      (ser_rx_full[c])
    );

    afp_fifo #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_tx (
      .clk       (clk),
      .rst       (rst),
      .clear     (!active[c]),
      .push      (cpu_push[c]),
      .push_data (bus_wdata[SAMPLE_W-1:0]),
      .pop       (ser_tx_pop[c] && active[c]),
      .bot_data  (tx_bot),
      .bot_valid (tx_v),
      .full      (tx_full)
    );

    // a full chain accepts a push only when the bottom leaves the same clock
    assign tx_drop[c] = cpu_push[c] && tx_full && !ser_tx_pop[c];

    always_ff @(posedge clk) begin
      if (rst || !active[c]) ovf_q <= 1'b0;
      else if (tx_drop[c]) ovf_q <= 1'b1;
    end

    assign cpu_rx_empty[c] = !rx_v;
    assign ser_tx_empty[c] = !tx_v;
    assign cpu_tx_full[c]  = tx_full;
    assign tx_ovf[c]       = ovf_q;
    assign ser_tx_data[c*SAMPLE_W +: SAMPLE_W] = tx_bot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      for (int c = 0; c < NCH; c++)
        if (bus_addr == chan_addr(c) && active[c]) bus_rdata <= BUS_W'(rx_bot[c]);
    end
  end

endmodule

// File: rtl/afp_checker.sv
module afp_checker
  import afp_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [1:0]       bus_addr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [BUS_W-1:0] bus_rdata,
  input logic [1:0]       en_q,
  input logic [1:0]       active,
  input logic [1:0]       tx_drop,
  input logic [1:0]       tx_ovf,
  input logic [1:0]       cpu_rx_empty,
  input logic [1:0]       ser_tx_empty,
  input logic [1:0]       chan_ready
);

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[BUS_W-1:16] == '0);

  assert_foreign_code_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_CTRL && sel_decode(bus_wdata[SEL_HI:SEL_LO]) == 2'b00)
      |=> $stable(en_q));

  assert_ready_lag_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> chan_ready == $past(en_q));

  for (genvar c = 0; c < 2; c++) begin : g_chk
    assert_disabled_clear_R6: assert property (@(posedge clk) disable iff (rst)
      !active[c] |=> (cpu_rx_empty[c] && ser_tx_empty[c] && !tx_ovf[c]));

    assert_drop_flags_R8: assert property (@(posedge clk) disable iff (rst)
      tx_drop[c] |=> tx_ovf[c]);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (tx_ovf[c] && active[c]) |=> tx_ovf[c]);

    assert_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == chan_addr(c) && cpu_rx_empty[c]) |=> bus_rdata == '0);
  end

endmodule

bind audio_fifo_port afp_checker #(.BUS_W(BUS_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .en_q         (en_q),
  .active       (active),
  .tx_drop      (tx_drop),
  .tx_ovf       (tx_ovf),
  .cpu_rx_empty (cpu_rx_empty),
  .ser_tx_empty (ser_tx_empty),
  .chan_ready   (chan_ready)
);

// File: tb/sim_audio_fifo_port.sv
module sim_audio_fifo_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iface_en = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  ser_rx_push = '0;
  logic [31:0] ser_rx_data = '0;
  logic [1:0]  ser_rx_full;
  logic [1:0]  ser_tx_pop = '0;
  logic [31:0] ser_tx_data;
  logic [1:0]  ser_tx_empty;
  logic [1:0]  cpu_rx_empty;
  logic [1:0]  cpu_tx_full;
  logic [1:0]  tx_ovf;
  logic [1:0]  chan_ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  audio_fifo_port u0 (.*);

  localparam logic [2:0] K_WR = 0, K_RD = 1, K_PUSH = 2, K_POP = 3, K_IDLE = 4;

  typedef struct packed {
    logic [2:0]  kind;
    logic [1:0]  sel;     // bus address, or channel for serial steps
    logic [31:0] data;    // write data, push sample, or idle count
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{K_WR,   2'd0, 32'hFFF1_8000, 32'h0,      4'd5},  // R5 right enable, reserved bits set
    '{K_IDLE, 2'd0, 32'd2,         32'h0,      4'd5},
    '{K_WR,   2'd1, 32'hABCD_1234, 32'h0,      4'd1},  // R1 upper half ignored
    '{K_WR,   2'd1, 32'h0000_5555, 32'h0,      4'd4},
    '{K_WR,   2'd2, 32'h0000_BEEF, 32'h0,      4'd4},
    '{K_IDLE, 2'd0, 32'd10,        32'h0,      4'd4},
    '{K_POP,  2'd0, 32'h0,         32'h1234,   4'd4},  // R4 oldest first
    '{K_POP,  2'd0, 32'h0,         32'h5555,   4'd4},
    '{K_POP,  2'd1, 32'h0,         32'hBEEF,   4'd4},
    '{K_PUSH, 2'd1, 32'h0A0A,      32'h0,      4'd2},
    '{K_PUSH, 2'd1, 32'h0B0B,      32'h0,      4'd2},
    '{K_IDLE, 2'd0, 32'd10,        32'h0,      4'd2},
    '{K_RD,   2'd2, 32'h0,         32'h0A0A,   4'd2},  // R2
    '{K_RD,   2'd2, 32'h0,         32'h0B0B,   4'd2},
    '{K_RD,   2'd2, 32'h0,         32'h0,      4'd7},  // R7 empty read
    '{K_RD,   2'd0, 32'h0,         32'h0,      4'd1},  // R1 control reads zero
    '{K_RD,   2'd3, 32'h0,         32'h0,      4'd1}   // R1 unused address
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rx_push(input int c, input logic [15:0] v);
    @(negedge clk);
    ser_rx_push[c] = 1'b1; ser_rx_data[c*16 +: 16] = v;
    @(negedge clk);
    ser_rx_push[c] = 1'b0;
  endtask

  task automatic tx_pop(input int c, output logic [15:0] v);
    @(negedge clk);
    v = ser_tx_data[c*16 +: 16];
    ser_tx_pop[c] = 1'b1;
    @(negedge clk);
    ser_tx_pop[c] = 1'b0;
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] sv;

    idle(3);
    rst = 1'b0;
    idle(1);
    // reset state
    check("R9 reset ready", 32'(chan_ready), 32'h0);
    check("R6 reset rx empty", 32'(cpu_rx_empty), 32'h3);
    check("R6 reset tx empty", 32'(ser_tx_empty), 32'h3);
    check("R8 reset ovf", 32'(tx_ovf), 32'h0);
    check("R1 reset rdata", bus_rdata, 32'h0);

    // R9: ready trails the enable by one clock
    bus_write(2'd0, 32'h000D_8000);
    check("R9 ready not yet", 32'(chan_ready), 32'h0);
    idle(1);
    check("R9 ready left", 32'(chan_ready), 32'h1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        K_WR:   bus_write(VEC[i].sel, VEC[i].data);
        K_RD: begin
          bus_read(VEC[i].sel, rd);
          check($sformatf("R%0d table step %0d", VEC[i].req, i), rd, VEC[i].exp);
        end
        K_PUSH: rx_push(int'(VEC[i].sel), VEC[i].data[15:0]);
        K_POP: begin
          tx_pop(int'(VEC[i].sel), sv);
          check($sformatf("R%0d table step %0d", VEC[i].req, i), 32'(sv), VEC[i].exp);
        end
        default: idle(int'(VEC[i].data));
      endcase
    end
    check("R5 both enabled", 32'(chan_ready), 32'h3);

    // R5: foreign codes change nothing
    bus_write(2'd0, 32'h000E_0000);
    bus_write(2'd0, 32'h0001_0000);
    bus_write(2'd0, 32'h0010_0000);
    idle(2);
    check("R5 foreign code", 32'(chan_ready), 32'h3);

    // R3: fall-through time of a single sample
    rx_push(0, 16'h7777);
    idle(6);
    check("R3 still falling", 32'(cpu_rx_empty[0]), 32'h1);
    idle(1);
    check("R3 landed", 32'(cpu_rx_empty[0]), 32'h0);
    bus_read(2'd1, rd);
    check("R3 sample value", rd, 32'h7777);

    // R10: overfill receive
    for (int i = 0; i < 9; i++) rx_push(0, 16'(16'h0100 + i));
    idle(10);
    check("R10 rx full", 32'(ser_rx_full[0]), 32'h1);
    for (int i = 0; i < 8; i++) begin
      bus_read(2'd1, rd);
      check("R10 rx order", rd, 32'(16'h0100 + i));
    end
    bus_read(2'd1, rd);
    check("R10 ninth dropped", rd, 32'h0);
    check("R7 empty after drain", 32'(cpu_rx_empty[0]), 32'h1);

    // R8: overfill transmit
    for (int i = 0; i < 9; i++) bus_write(2'd1, 32'(16'h0200 + i));
    idle(10);
    check("R8 tx full", 32'(cpu_tx_full[0]), 32'h1);
    check("R8 ovf set", 32'(tx_ovf[0]), 32'h1);
    for (int i = 0; i < 8; i++) begin
      tx_pop(0, sv);
      check("R8 tx order", 32'(sv), 32'(16'h0200 + i));
    end
    idle(2);
    check("R8 ninth dropped", 32'(ser_tx_empty[0]), 32'h1);
    check("R8 ovf sticky", 32'(tx_ovf[0]), 32'h1);

    // R6: disable clears and blocks
    rx_push(1, 16'hCAFE);
    idle(10);
    check("R6 right holds data", 32'(cpu_rx_empty[1]), 32'h0);
    bus_write(2'd0, 32'h0011_0000);
    idle(1);
    check("R6 right cleared", 32'(cpu_rx_empty[1]), 32'h1);
    check("R6 right ready low", 32'(chan_ready[1]), 32'h0);
    rx_push(1, 16'h1357);
    bus_write(2'd2, 32'h0000_2468);
    idle(10);
    check("R6 disabled rx push", 32'(cpu_rx_empty[1]), 32'h1);
    check("R6 disabled tx write", 32'(ser_tx_empty[1]), 32'h1);
    bus_read(2'd2, rd);
    check("R6 disabled read", rd, 32'h0);
    bus_write(2'd0, 32'h000D_0000);
    idle(1);
    check("R6 ovf cleared", 32'(tx_ovf[0]), 32'h0);

    // R6: interface enable low clears enabled channel
    bus_write(2'd0, 32'h000D_8000);
    idle(2);
    bus_write(2'd1, 32'h0000_3333);
    idle(10);
    check("R6 tx loaded", 32'(ser_tx_empty[0]), 32'h0);
    @(negedge clk); iface_en = 1'b0;
    @(negedge clk); iface_en = 1'b1;
    idle(1);
    check("R6 iface clear", 32'(ser_tx_empty[0]), 32'h1);
    check("R6 enable kept", 32'(chan_ready[0]), 32'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule